// File: doc/BRIEF.md
# Selectable-Polynomial Serial CRC Engine

This block computes a 16-bit cyclic redundancy check over serial data for a synchronous line controller. The receive and transmit directions each have their own 16-bit register. One configuration pin picks the polynomial and applies to both directions. Another pin picks the preset value, all ones or all zeros. A `frame_start` pulse loads the preset into both registers.

On receive, bits arrive one per `rx_valid` cycle, and `rx_char_end` marks the last bit of a character. A completed character is not added to the check at once. It waits in a holding register until the next character boundary or the end of the frame. During that wait, a pulse on `rx_exclude` drops it from the sum. This lets the controlling logic leave sync or fill characters out of the check after it has seen them. At `rx_frame_end`, the residual is tested and `crc_err` reports the result.

On transmit, data bits pass from a valid/ready source to a valid/ready line sink, and each accepted bit updates the transmit register. When the line asks for a bit and the source has none, the frame is treated as finished. The engine then sends the 16 check bits by itself, most significant first. The receive bit input never applies back-pressure, so `rx_ready` is held high. On the transmit side, the line's `tx_out_ready` is passed back to the source as `tx_in_ready` while data flows, and is forced low while check bits are going out.

Top module: `crc_engine`

## Requirements
- R1: With `cfg_poly_ccitt`=1 the generator is 0x1021 (x^16+x^12+x^5+1); with 0 it is 0x8005 (x^16+x^15+x^2+1). The register shifts left, and each data bit is fed in the order it arrives: feedback = reg[15] XOR bit. The result is neither reflected nor inverted.
- R2: A `frame_start` pulse loads both registers with 0xFFFF when `cfg_preset_ones`=1 and with 0x0000 otherwise. From the next cycle `crc_err` reads 0.
- R3: A receive character is captured when `rx_char_end` comes with `rx_valid`. It is added to the receive register only at the next character boundary, or at `rx_frame_end` for the last one.
- R4: If `rx_exclude` is high in any cycle while a character is held, that character is never added. This includes the cycle of the next boundary or of `rx_frame_end`.
- R5: At `rx_frame_end` the residual, including any held character, is judged. It passes when it is 0x0000, or when it is 0x1D0F with the CCITT polynomial and the all-ones preset. Otherwise `crc_err` is 1 from the next cycle until the next `frame_start`.
- R6: A receive character may be 1 to CHAR_W bits long. Only the bits actually received are added.
- R7: While no check bits are being sent, `tx_out_valid`/`tx_out_bit` follow `tx_in_valid`/`tx_in_bit` and `tx_in_ready` equals `tx_out_ready`. Every transferred bit updates the transmit register.
- R8: After at least one data bit since the last preset, a cycle with `tx_out_ready`=1 and `tx_in_valid`=0 starts check output from the next cycle. Then 16 bits are sent, most significant first, with `tx_crc_active`=1, `tx_out_valid`=1 and `tx_in_ready`=0.
- R9: While `tx_out_ready` is low during check output, `tx_out_bit` holds its value.
- R10: After the 16th check bit, the transmit register is preset again from the current configuration, and no check output starts until a new data bit has passed.
- R11: After reset `crc_err`, `tx_crc_active` and `tx_out_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_poly_ccitt | input | 1 | 1 selects CCITT, 0 selects CRC-16; held steady within a frame |
| cfg_preset_ones | input | 1 | 1 presets to all ones, 0 to all zeros |
| frame_start | input | 1 | Preset both registers and clear the error flag |
| rx_valid | input | 1 | A receive bit is present |
| rx_ready | output | 1 | Always 1; receive side never stalls |
| rx_bit | input | 1 | Receive serial data |
| rx_char_end | input | 1 | With rx_valid: this bit closes a character |
| rx_exclude | input | 1 | Keep the held receive character out of the check |
| rx_frame_end | input | 1 | Judge the residual of the receive frame |
| crc_err | output | 1 | Receive check failed |
| tx_in_valid | input | 1 | Transmit source has a data bit |
| tx_in_ready | output | 1 | Transmit source bit is taken |
| tx_in_bit | input | 1 | Transmit source data bit |
| tx_out_valid | output | 1 | Line bit is present |
| tx_out_ready | input | 1 | Line takes a bit this cycle |
| tx_out_bit | output | 1 | Line serial data, data or check bits |
| tx_crc_active | output | 1 | Check bits are being sent |

## Verification
The bench goes after the delayed fold and its exclusion window. It excludes characters in the middle of the following character, on the boundary cycle itself, and for the last data character while the first check byte arrives. A design that folded characters on arrival, or that lost the same-cycle exclusion, would flag good frames as bad. It also checks short characters, which catch a design that pads them to full width, and both residual constants for the all-ones preset. A wrong polynomial choice would accept an inverted check under CRC-16. On transmit it checks the exact check bits with a mid-stream line stall, that no check is sent before data, and a second frame without `frame_start`. These would expose a design that drops a bit during the stall or fails to preset again after the check.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;
  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] POLY_CCITT = 16'h1021;
  localparam logic [CRC_W-1:0] POLY_CRC16 = 16'h8005;
  localparam logic [CRC_W-1:0] RESID_CCITT_ONES = 16'h1D0F;

  // One LFSR step, data bit fed against the top bit.
  function automatic logic [CRC_W-1:0] crc_bit(input logic [CRC_W-1:0] c,
                                               input logic b,
                                               input logic ccitt);
    logic fb;
    logic [CRC_W-1:0] p;
    fb = c[CRC_W-1] ^ b;
    p  = ccitt ? POLY_CCITT : POLY_CRC16;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? p : '0);
  endfunction

  function automatic logic [CRC_W-1:0] preset_val(input logic ones);
    return ones ? '1 : '0;
  endfunction
endpackage

// File: rtl/crc_rx_delay.sv
module crc_rx_delay
  import crc_eng_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_poly_ccitt,
  input  logic cfg_preset_ones,
  input  logic frame_start,
  input  logic rx_valid,
  input  logic rx_bit,
  input  logic rx_char_end,
  input  logic rx_exclude,
  input  logic rx_frame_end,
  output logic crc_err
);
  localparam int LEN_W = $clog2(CHAR_W + 1);

  logic [CHAR_W-1:0] cap_sh;
  logic [LEN_W-1:0]  cap_len;
  logic [CHAR_W-1:0] pend;      // left-aligned held character
  logic [LEN_W-1:0]  pend_len;
  logic              pend_vld;
  logic              pend_excl;
  logic [CRC_W-1:0]  crc_q;
  logic              err_q;

  logic [CHAR_W-1:0] new_char;
  logic [LEN_W-1:0]  new_len;
  logic              fold_en;
  logic [CRC_W-1:0]  folded;
  logic [CRC_W-1:0]  resid;
  logic              resid_ok;
  logic              boundary;

  assign new_char = {cap_sh[CHAR_W-2:0], rx_bit};
  assign new_len  = cap_len + 1'b1;
  assign fold_en  = pend_vld && !(pend_excl || rx_exclude);
  assign boundary = rx_valid && rx_char_end;

  // Unrolled fold of the held character, first-received bit first.
  always_comb begin
    folded = crc_q;
    for (int i = 0; i < CHAR_W; i++) begin
      if (i < int'(pend_len)) folded = crc_bit(folded, pend[CHAR_W-1-i], cfg_poly_ccitt);
    end
  end

  assign resid    = fold_en ? folded : crc_q;
  assign resid_ok = (resid == '0) ||
                    (cfg_poly_ccitt && cfg_preset_ones && resid == RESID_CCITT_ONES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_sh    <= '0;
      cap_len   <= '0;
      pend      <= '0;
      pend_len  <= '0;
      pend_vld  <= 1'b0;
      pend_excl <= 1'b0;
      crc_q     <= '0;
      err_q     <= 1'b0;
    end else if (frame_start) begin
      crc_q     <= preset_val(cfg_preset_ones);
      cap_sh    <= '0;
      cap_len   <= '0;
      pend_vld  <= 1'b0;
      pend_excl <= 1'b0;
      err_q     <= 1'b0;
    end else if (rx_frame_end) begin
      err_q     <= !resid_ok;
      crc_q     <= preset_val(cfg_preset_ones);
      cap_sh    <= '0;
      cap_len   <= '0;
      pend_vld  <= 1'b0;
      pend_excl <= 1'b0;
    end else if (boundary) begin
      crc_q     <= resid;
      pend      <= new_char << (CHAR_W - int'(new_len));
      pend_len  <= new_len;
      pend_vld  <= 1'b1;
      pend_excl <= 1'b0;
      cap_sh    <= '0;
      cap_len   <= '0;
    end else begin
      if (rx_valid) begin
        cap_sh  <= new_char;
        cap_len <= new_len;
      end
      if (pend_vld && rx_exclude) pend_excl <= 1'b1;
    end
  end

  assign crc_err = err_q;

  // R2: preset value loaded by frame_start
  a_r2_preset_load: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (crc_q == preset_val($past(cfg_preset_ones))));
  // R2: error flag cleared by frame_start
  a_r2_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !crc_err);
  // R3: nothing held over past the end of a frame
  a_r3_frame_flush: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frame_end |=> !pend_vld);
  // R6: a character never grows past CHAR_W bits
  a_r6_char_fits: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_char_end && !frame_start && !rx_frame_end) |-> (int'(cap_len) < CHAR_W - 1));
endmodule

// File: rtl/crc_tx_append.sv
module crc_tx_append
  import crc_eng_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_poly_ccitt,
  input  logic cfg_preset_ones,
  input  logic frame_start,
  input  logic tx_in_valid,
  output logic tx_in_ready,
  input  logic tx_in_bit,
  output logic tx_out_valid,
  input  logic tx_out_ready,
  output logic tx_out_bit,
  output logic tx_crc_active
);
  localparam int CNT_W = $clog2(CRC_W);

  logic [CRC_W-1:0] crc_q;
  logic             sending;
  logic             armed;
  logic [CNT_W-1:0] cnt;

  assign tx_in_ready   = !sending && tx_out_ready;
  assign tx_out_valid  = sending || tx_in_valid;
  assign tx_out_bit    = sending ? crc_q[CRC_W-1] : tx_in_bit;
  assign tx_crc_active = sending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q   <= '0;
      sending <= 1'b0;
      armed   <= 1'b0;
      cnt     <= '0;
    end else if (frame_start) begin
      crc_q   <= preset_val(cfg_preset_ones);
      sending <= 1'b0;
      armed   <= 1'b0;
      cnt     <= '0;
    end else if (sending) begin
      if (tx_out_ready) begin
        if (cnt == CNT_W'(CRC_W - 1)) begin
          sending <= 1'b0;
          armed   <= 1'b0;
          cnt     <= '0;
          crc_q   <= preset_val(cfg_preset_ones);
        end else begin
          cnt     <= cnt + 1'b1;
          crc_q   <= {crc_q[CRC_W-2:0], 1'b0};
        end
      end
    end else if (tx_out_ready) begin
      if (tx_in_valid) begin
        crc_q <= crc_bit(crc_q, tx_in_bit, cfg_poly_ccitt);
        armed <= 1'b1;
      end else if (armed) begin
        sending <= 1'b1;
        cnt     <= '0;
      end
    end
  end

  // R8: check output only starts on a starved source
  a_r8_start_on_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_crc_active) |-> ($past(!tx_in_valid) && $past(tx_out_ready)));
  // R9: line stall holds the check bit
  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_crc_active && !tx_out_ready && !frame_start) |=> $stable(tx_out_bit));
  // R10: register is back at a preset value after the check
  a_r10_represet: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_crc_active) |-> (crc_q == '0 || crc_q == '1));
endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_eng_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_poly_ccitt,
  input  logic cfg_preset_ones,
  input  logic frame_start,
  input  logic rx_valid,
  output logic rx_ready,
  input  logic rx_bit,
  input  logic rx_char_end,
  input  logic rx_exclude,
  input  logic rx_frame_end,
  output logic crc_err,
  input  logic tx_in_valid,
  output logic tx_in_ready,
  input  logic tx_in_bit,
  output logic tx_out_valid,
  input  logic tx_out_ready,
  output logic tx_out_bit,
  output logic tx_crc_active
);
  assign rx_ready = 1'b1;

  crc_rx_delay #(.CHAR_W(CHAR_W)) u_rx (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_poly_ccitt  (cfg_poly_ccitt),
    .cfg_preset_ones (cfg_preset_ones),
    .frame_start     (frame_start),
    .rx_valid        (rx_valid),
    .rx_bit          (rx_bit),
    .rx_char_end     (rx_char_end),
    .rx_exclude      (rx_exclude),
    .rx_frame_end    (rx_frame_end),
    .crc_err         (crc_err)
  );

  crc_tx_append u_tx (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_poly_ccitt  (cfg_poly_ccitt),
    .cfg_preset_ones (cfg_preset_ones),
    .frame_start     (frame_start),
    .tx_in_valid     (tx_in_valid),
    .tx_in_ready     (tx_in_ready),
    .tx_in_bit       (tx_in_bit),
    .tx_out_valid    (tx_out_valid),
    .tx_out_ready    (tx_out_ready),
    .tx_out_bit      (tx_out_bit),
    .tx_crc_active   (tx_crc_active)
  );

  // R11: quiet outputs right after reset
  a_r11_reset_quiet: assert property (@(posedge clk)
    $rose(rst_n) |-> (!crc_err && !tx_crc_active));
endmodule

// File: tb/crc_engine_test.sv
module crc_engine_test;
  logic clk = 0;
  logic rst_n = 0;
  logic cfg_poly_ccitt = 0, cfg_preset_ones = 0, frame_start = 0;
  logic rx_valid = 0, rx_bit = 0, rx_char_end = 0, rx_exclude = 0, rx_frame_end = 0;
  logic tx_in_valid = 0, tx_in_bit = 0, tx_out_ready = 0;
  logic rx_ready, crc_err, tx_in_ready, tx_out_valid, tx_out_bit, tx_crc_active;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  crc_engine #(.CHAR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_poly_ccitt(cfg_poly_ccitt), .cfg_preset_ones(cfg_preset_ones),
    .frame_start(frame_start), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_bit(rx_bit),
    .rx_char_end(rx_char_end), .rx_exclude(rx_exclude), .rx_frame_end(rx_frame_end),
    .crc_err(crc_err), .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_bit(tx_in_bit),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_bit(tx_out_bit),
    .tx_crc_active(tx_crc_active)
  );

  // {ccitt, ones, corrupt, exclude[3:0], data[31:0]}
  localparam logic [38:0] VEC [6] = '{
    {1'b0, 1'b0, 1'b0, 4'b0000, 32'h3132_3334},
    {1'b1, 1'b1, 1'b0, 4'b0000, 32'hC0FF_EE01},
    {1'b1, 1'b0, 1'b1, 4'b0000, 32'h5A5A_0F0F},
    {1'b0, 1'b1, 1'b0, 4'b0010, 32'h1234_5678},
    {1'b1, 1'b1, 1'b0, 4'b1001, 32'hDEAD_BEEF},
    {1'b0, 1'b0, 1'b1, 4'b0100, 32'h8000_0001}
  };

  function automatic logic [15:0] mstep(logic [15:0] c, logic b, logic ccitt);
    logic [15:0] p;
    p = ccitt ? 16'h1021 : 16'h8005;
    return (c[15] ^ b) ? ({c[14:0], 1'b0} ^ p) : {c[14:0], 1'b0};
  endfunction

  function automatic logic [15:0] mfold(logic [15:0] c, logic [7:0] v, int len, logic ccitt);
    logic [15:0] r;
    r = c;
    for (int i = len - 1; i >= 0; i--) r = mstep(r, v[i], ccitt);
    return r;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse_start(logic ccitt, logic ones);
    cfg_poly_ccitt = ccitt;
    cfg_preset_ones = ones;
    frame_start = 1;
    tick();
    frame_start = 0;
  endtask

  task automatic send_char(logic [7:0] v, int len, bit ex_mid, bit ex_end);
    for (int i = len - 1; i >= 0; i--) begin
      rx_valid = 1;
      rx_bit = v[i];
      rx_char_end = (i == 0);
      rx_exclude = (ex_mid && i == 1) || (ex_end && i == 0);
      tick();
    end
    rx_valid = 0;
    rx_char_end = 0;
    rx_exclude = 0;
  endtask

  task automatic end_frame();
    rx_frame_end = 1;
    tick();
    rx_frame_end = 0;
  endtask

  // mode 0: correct check, 1: corrupted, 2: inverted check appended
  task automatic rx_frame(logic ccitt, logic ones, logic [31:0] d, int nb, logic [3:0] ex,
                          int mode, logic exp_err, string tag);
    logic [15:0] c, cv;
    pulse_start(ccitt, ones);
    c = ones ? 16'hFFFF : 16'h0000;
    for (int k = 0; k < nb; k++) begin
      send_char(d[31-8*k -: 8], 8, (k > 0) && ex[k-1], 0);
      if (!ex[k]) c = mfold(c, d[31-8*k -: 8], 8, ccitt);
    end
    cv = (mode == 2) ? ~c : c;
    if (mode == 1) cv = cv ^ 16'h0100;
    send_char(cv[15:8], 8, ex[nb-1], 0);
    send_char(cv[7:0], 8, 0, 0);
    end_frame();
    chk(crc_err == exp_err, tag, {31'd0, crc_err}, {31'd0, exp_err});
  endtask

  task automatic tx_byte(logic [7:0] v, logic ccitt, inout logic [15:0] c);
    for (int i = 7; i >= 0; i--) begin
      tx_in_valid = 1;
      tx_in_bit = v[i];
      #1;
      chk(tx_out_valid && tx_out_bit == v[i] && tx_in_ready && !tx_crc_active,
          "R7 data passes to line", {29'd0, tx_out_valid, tx_out_bit, tx_in_ready}, {29'd0, 1'b1, v[i], 1'b1});
      c = mstep(c, v[i], ccitt);
      tick();
    end
    tx_in_valid = 0;
  endtask

  task automatic tx_collect(logic [15:0] exp, bit stall, string tag);
    logic [15:0] got;
    logic hold;
    bit side_ok;
    got = 0;
    side_ok = 1;
    tick();
    for (int i = 15; i >= 0; i--) begin
      if (stall && i == 10) begin
        tx_out_ready = 0;
        hold = tx_out_bit;
        tick();
        tick();
        chk(tx_out_bit == hold && tx_crc_active, "R9 stalled check bit held",
            {31'd0, tx_out_bit}, {31'd0, hold});
        tx_out_ready = 1;
      end
      got[i] = tx_out_bit;
      if (!(tx_out_valid && tx_crc_active && !tx_in_ready)) side_ok = 0;
      tick();
    end
    chk(got == exp, tag, {16'd0, got}, {16'd0, exp});
    chk(side_ok, "R8 active/valid high and source stalled during check", {31'd0, side_ok}, 32'd1);
    chk(!tx_crc_active && !tx_out_valid, "R10 check output ends after 16 bits",
        {30'd0, tx_crc_active, tx_out_valid}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] c;
    repeat (3) tick();
    // R11 reset state
    chk(!crc_err && !tx_crc_active && !tx_out_valid, "R11 reset state",
        {29'd0, crc_err, tx_crc_active, tx_out_valid}, 32'd0);
    rst_n = 1;
    tick();
    chk(rx_ready, "R11 rx_ready high", {31'd0, rx_ready}, 32'd1);

    // Vector table: R1 polynomials, R3 delayed fold, R4 exclusion, R5 judgement
    for (int v = 0; v < 6; v++) begin
      rx_frame(VEC[v][38], VEC[v][37], VEC[v][31:0], 4, VEC[v][35:32],
               VEC[v][36] ? 1 : 0, VEC[v][36], $sformatf("R1/R3/R4/R5 vector %0d", v));
      if (VEC[v][36]) begin
        pulse_start(VEC[v][38], VEC[v][37]);
        chk(!crc_err, "R2 frame_start clears error", {31'd0, crc_err}, 32'd0);
      end
    end

    // R5: inverted check gives 0x1D0F residual, accepted only for CCITT + ones
    rx_frame(1, 1, 32'hA1B2_0000, 2, 4'b0000, 2, 0, "R5 CCITT ones residual 1D0F passes");
    rx_frame(0, 1, 32'hA1B2_0000, 2, 4'b0000, 2, 1, "R5 CRC-16 inverted check fails");
    rx_frame(1, 0, 32'hA1B2_0000, 2, 4'b0000, 2, 1, "R5 CCITT zeros inverted check fails");

    // R4: exclusion on the boundary cycle of the next character
    pulse_start(1, 0);
    send_char(8'hA5, 8, 0, 0);
    send_char(8'h3C, 8, 0, 1);
    c = mfold(16'h0000, 8'h3C, 8, 1);
    send_char(c[15:8], 8, 0, 0);
    send_char(c[7:0], 8, 0, 0);
    end_frame();
    chk(!crc_err, "R4 exclude on boundary cycle", {31'd0, crc_err}, 32'd0);

    // R6: five-bit characters
    pulse_start(0, 0);
    c = 16'h0000;
    send_char(8'h13, 5, 0, 0);
    c = mfold(c, 8'h13, 5, 0);
    send_char(8'h0A, 5, 0, 0);
    c = mfold(c, 8'h0A, 5, 0);
    send_char(8'h1F, 5, 0, 0);
    c = mfold(c, 8'h1F, 5, 0);
    send_char(c[15:8], 8, 0, 0);
    send_char(c[7:0], 8, 0, 0);
    end_frame();
    chk(!crc_err, "R6 short characters", {31'd0, crc_err}, 32'd0);

    // Transmit: R10 no check before data, R7 pass-through, R8 check, R9 stall
    pulse_start(1, 1);
    tx_out_ready = 1;
    tick();
    tick();
    chk(!tx_crc_active && !tx_out_valid, "R10 no check output before data",
        {30'd0, tx_crc_active, tx_out_valid}, 32'd0);
    c = 16'hFFFF;
    tx_byte(8'h31, 1, c);
    tx_byte(8'h32, 1, c);
    tx_collect(c, 1, "R8 CCITT check bits");
    // R10: second frame without frame_start uses fresh preset
    tick();
    chk(!tx_crc_active, "R10 idle after check", {31'd0, tx_crc_active}, 32'd0);
    c = 16'hFFFF;
    tx_byte(8'h7E, 1, c);
    tx_collect(c, 0, "R10 check after re-preset");
    // R1/R8: CRC-16 zeros on transmit
    pulse_start(0, 0);
    c = 16'h0000;
    tx_byte(8'hC3, 0, c);
    tx_byte(8'h01, 0, c);
    tx_collect(c, 0, "R1 CRC-16 transmit check");
    tx_out_ready = 0;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule